// File: doc/BRIEF.md
# Receiver Automatic Gain Loop Controller

This block closes a digital gain loop around a receiver's analog chain. It gathers A/D statistics over fixed windows of valid samples: how many samples hit the converter rail, and the largest magnitude seen. From that summary it walks an IF gain code down from its maximum until the peak amplitude lands in a target band.

The size of each downward step follows how hard the converter was clipping. Once the peak is inside the band, the controller locks and holds the gain for the rest of the packet. It reports each new lock with a one-cycle pulse, which the wider receiver treats as a hint that a signal is present. A locked loop releases when the peak drifts too far from the level it locked at.

A separate hysteretic decision turns the RF low-noise amplifier off for strong inputs and back on for weak ones. Each switch moves 30 dB of gain between the RF stage and the IF code, so the total gain stays level. A `rx_start` pulse re-arms everything at the start of a reception.

Top module: `agc_ctrl`

## Requirements
- R1: After `rst`, or one cycle after a `rx_start` pulse, `gain_code` is 90 (GAIN_MAX), `lna_en` is 1, `agc_lock` is 0 and `lock_pulse` is 0.
- R2: A window holds 64 cycles with `smp_vld`=1; cycles with `smp_vld`=0 are not counted. Results of a window appear on the outputs two clock edges after the edge that captures its 64th valid sample.
- R3: While unlocked, a window with peak above 600 lowers the gain by 8 when more than 32 of its samples were saturated, by 4 when more than 6 were, and by 1 otherwise.
- R4: The gain code never goes below 0 and never above 90; each step that would leave that range is clamped.
- R5: While unlocked, a window whose peak lies in 400..600 (inclusive) sets `agc_lock`, stores that peak as the reference, and raises `lock_pulse` for exactly one cycle.
- R6: While locked, `gain_code` and `lna_en` do not change, and the lock holds while the peak differs from the reference by at most 150.
- R7: While locked, a window whose peak differs from the reference by more than 150 clears `agc_lock` and leaves the gain unchanged.
- R8: While unlocked with the LNA on, a window that ends with `rf_pwr` above 200 turns the LNA off and adds 30 to the gain (clamped); no amplitude step is taken in that window.
- R9: While unlocked with the LNA off, a window that ends with `rf_pwr` below 150 turns the LNA on and subtracts 30 from the gain (clamped); a level from 150 to 200 keeps the current LNA state.
- R10: While unlocked, a window whose peak is below 400 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_start | input | 1 | Start of reception; re-arms the loop |
| smp_vld | input | 1 | A/D sample valid this cycle |
| smp_sat | input | 1 | Sample is at the converter rail |
| smp_mag | input | AW (10) | Sample magnitude |
| rf_pwr | input | PW (8) | RF stage power level |
| gain_code | output | GW (7) | IF gain code in dB |
| lna_en | output | 1 | LNA enable |
| agc_lock | output | 1 | Loop locked |
| lock_pulse | output | 1 | One-cycle pulse on unlocked-to-locked |

## Verification
The statistics register closes a window on the edge that takes its 64th valid sample. The decision register acts on the following edge, so every output result is due two edges after that last sample. The bench drives each sample on a falling edge and then idles one more falling edge before sampling gain, LNA, lock and pulse, so it reads exactly the cycle the decision lands in. One cycle later it checks that the lock pulse has fallen. The valid-gap test holds a window one sample short across idle cycles and confirms nothing moves until that final sample arrives.

// File: rtl/agc_pkg.sv
package agc_pkg;
  typedef enum logic [1:0] {
    STEP_FINE   = 2'd0,
    STEP_MID    = 2'd1,
    STEP_COARSE = 2'd2
  } step_cls_e;

  function automatic int clamp_add(input int base, input int delta, input int hi);
    int r;
    r = base + delta;
    if (r < 0) r = 0;
    if (r > hi) r = hi;
    return r;
  endfunction

  function automatic int abs_diff(input int a, input int b);
    return (a > b) ? (a - b) : (b - a);
  endfunction
endpackage

// File: rtl/agc_win_meas.sv
module agc_win_meas #(
  parameter int WIN = 64,
  parameter int AW  = 10,
  parameter int CW  = $clog2(WIN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          smp_vld,
  input  logic          smp_sat,
  input  logic [AW-1:0] smp_mag,
  output logic          win_done,
  output logic [CW-1:0] win_sat,
  output logic [AW-1:0] win_peak
);
  localparam int IW = (WIN > 1) ? $clog2(WIN) : 1;

  logic [IW-1:0] cnt_q;
  logic [CW-1:0] sat_q;
  logic [AW-1:0] pk_q;
  logic [CW-1:0] sat_nxt;
  logic [AW-1:0] pk_nxt;

  always_comb begin
    sat_nxt = sat_q + CW'(smp_sat);
    pk_nxt  = (smp_mag > pk_q) ? smp_mag : pk_q;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q    <= '0;
      sat_q    <= '0;
      pk_q     <= '0;
      win_done <= 1'b0;
      win_sat  <= '0;
      win_peak <= '0;
    end else begin
      win_done <= 1'b0;
      if (smp_vld) begin
        if (cnt_q == IW'(WIN - 1)) begin
          win_done <= 1'b1;
          win_sat  <= sat_nxt;
          win_peak <= pk_nxt;
          cnt_q    <= '0;
          sat_q    <= '0;
          pk_q     <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
          sat_q <= sat_nxt;
          pk_q  <= pk_nxt;
        end
      end
    end
  end
endmodule

// File: rtl/agc_step_sel.sv
module agc_step_sel
  import agc_pkg::*;
#(
  parameter int WIN       = 64,
  parameter int CW        = $clog2(WIN + 1),
  parameter int GW        = 7,
  parameter int HEAVY_PCT = 50,
  parameter int MID_PCT   = 10,
  parameter int COARSE_DB = 8,
  parameter int MID_DB    = 4,
  parameter int FINE_DB   = 1
) (
  input  logic [CW-1:0] sat_cnt,
  output step_cls_e     step_cls,
  output logic [GW-1:0] step_db
);
  always_comb begin
    if (int'(sat_cnt) * 100 > WIN * HEAVY_PCT) begin
      step_cls = STEP_COARSE;
      step_db  = GW'(COARSE_DB);
    end else if (int'(sat_cnt) * 100 > WIN * MID_PCT) begin
      step_cls = STEP_MID;
      step_db  = GW'(MID_DB);
    end else begin
      step_cls = STEP_FINE;
      step_db  = GW'(FINE_DB);
    end
  end
endmodule

// File: rtl/agc_lna_hyst.sv
module agc_lna_hyst #(
  parameter int PW    = 8,
  parameter int RF_HI = 200,
  parameter int RF_LO = 150
) (
  input  logic          lna_on_now,
  input  logic [PW-1:0] rf_pwr,
  output logic          go_off,
  output logic          go_on
);
  always_comb begin
    go_off = lna_on_now && (int'(rf_pwr) > RF_HI);
    go_on  = !lna_on_now && (int'(rf_pwr) < RF_LO);
  end
endmodule

// File: rtl/agc_ctrl.sv
module agc_ctrl
  import agc_pkg::*;
#(
  parameter int WIN      = 64,
  parameter int AW       = 10,
  parameter int PW       = 8,
  parameter int GAIN_MAX = 90,
  parameter int LNA_DB   = 30,
  parameter int LOCK_LO  = 400,
  parameter int LOCK_HI  = 600,
  parameter int DEV_MAX  = 150,
  parameter int RF_HI    = 200,
  parameter int RF_LO    = 150,
  localparam int GW      = $clog2(GAIN_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_start,
  input  logic          smp_vld,
  input  logic          smp_sat,
  input  logic [AW-1:0] smp_mag,
  input  logic [PW-1:0] rf_pwr,
  output logic [GW-1:0] gain_code,
  output logic          lna_en,
  output logic          agc_lock,
  output logic          lock_pulse
);
  localparam int CW = $clog2(WIN + 1);

  logic          win_done;
  logic [CW-1:0] win_sat;
  logic [AW-1:0] win_peak;
  step_cls_e     step_cls;
  logic [GW-1:0] step_db;
  logic          lna_go_off, lna_go_on;
  logic [AW-1:0] ref_q;
  logic          in_band, too_hot, drifted;

  agc_win_meas #(.WIN(WIN), .AW(AW), .CW(CW)) u_meas (
    .clk(clk), .rst(rst), .clr(rx_start),
    .smp_vld(smp_vld), .smp_sat(smp_sat), .smp_mag(smp_mag),
    .win_done(win_done), .win_sat(win_sat), .win_peak(win_peak)
  );

  agc_step_sel #(.WIN(WIN), .CW(CW), .GW(GW)) u_step (
    .sat_cnt(win_sat), .step_cls(step_cls), .step_db(step_db)
  );

  agc_lna_hyst #(.PW(PW), .RF_HI(RF_HI), .RF_LO(RF_LO)) u_lna (
    .lna_on_now(lna_en), .rf_pwr(rf_pwr),
    .go_off(lna_go_off), .go_on(lna_go_on)
  );

  always_comb begin
    in_band = (int'(win_peak) >= LOCK_LO) && (int'(win_peak) <= LOCK_HI);
    too_hot = int'(win_peak) > LOCK_HI;
    drifted = abs_diff(int'(win_peak), int'(ref_q)) > DEV_MAX;
  end

  always_ff @(posedge clk) begin
    if (rst || rx_start) begin
      gain_code  <= GW'(GAIN_MAX);
      lna_en     <= 1'b1;
      agc_lock   <= 1'b0;
      lock_pulse <= 1'b0;
      ref_q      <= '0;
    end else begin
      lock_pulse <= 1'b0;
      if (win_done) begin
        if (agc_lock) begin
          if (drifted) agc_lock <= 1'b0;
        end else if (lna_go_off) begin
          lna_en    <= 1'b0;
          gain_code <= GW'(clamp_add(int'(gain_code), LNA_DB, GAIN_MAX));
        end else if (lna_go_on) begin
          lna_en    <= 1'b1;
          gain_code <= GW'(clamp_add(int'(gain_code), -LNA_DB, GAIN_MAX));
        end else if (in_band) begin
          agc_lock   <= 1'b1;
          lock_pulse <= 1'b1;
          ref_q      <= win_peak;
        end else if (too_hot) begin
          gain_code <= GW'(clamp_add(int'(gain_code), -int'(step_db), GAIN_MAX));
        end
      end
    end
  end
endmodule

// File: rtl/agc_ctrl_chk.sv
module agc_ctrl_chk #(
  parameter int GAIN_MAX = 90,
  parameter int GW       = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          rx_start,
  input logic [GW-1:0] gain_code,
  input logic          lna_en,
  input logic          agc_lock,
  input logic          lock_pulse
);
  // R4
  gain_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(gain_code) <= GAIN_MAX);

  // R1
  restart_state_chk: assert property (@(posedge clk) disable iff (rst)
    rx_start |=> (int'(gain_code) == GAIN_MAX) && lna_en && !agc_lock && !lock_pulse);

  // R5
  pulse_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    lock_pulse |-> agc_lock && !$past(agc_lock));

  // R6
  locked_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (agc_lock && !rx_start) |=> $stable(gain_code) && $stable(lna_en));

  // R3
  step_bound_chk: assert property (@(posedge clk) disable iff (rst)
    ($stable(lna_en) && (gain_code < $past(gain_code)))
      |-> (int'($past(gain_code)) - int'(gain_code) <= 8));

  // R8
  rise_source_chk: assert property (@(posedge clk) disable iff (rst)
    (gain_code > $past(gain_code)) |-> ($fell(lna_en) || $past(rx_start)));

  // R8
  lna_off_unlocked_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(lna_en) |-> !$past(agc_lock));
endmodule

bind agc_ctrl agc_ctrl_chk #(.GAIN_MAX(GAIN_MAX), .GW(GW)) u_chk (
  .clk(clk), .rst(rst), .rx_start(rx_start), .gain_code(gain_code),
  .lna_en(lna_en), .agc_lock(agc_lock), .lock_pulse(lock_pulse)
);

// File: tb/agc_ctrl_bench.sv
module agc_ctrl_bench;
  localparam int AW = 10;
  localparam int PW = 8;
  localparam int GW = 7;
  localparam int NV = 17;

  // nsat, mag, rf, exp_gain, exp_lna, exp_lock, exp_pulse
  localparam int VEC [0:NV-1][0:6] = '{
    '{40, 900,   0, 82, 1, 0, 0},  // R3 coarse
    '{33, 900,   0, 74, 1, 0, 0},  // R3 coarse boundary
    '{32, 900,   0, 70, 1, 0, 0},  // R3 mid boundary
    '{ 7, 900,   0, 66, 1, 0, 0},  // R3 mid
    '{ 6, 900,   0, 65, 1, 0, 0},  // R3 fine boundary
    '{ 0, 700,   0, 64, 1, 0, 0},  // R3 fine
    '{ 0, 500,   0, 64, 1, 1, 1},  // R5 lock
    '{50, 900,   0, 64, 1, 0, 0},  // R7 drift unlock
    '{ 0, 590,   0, 64, 1, 1, 1},  // R5 relock at band edge
    '{ 0, 700,   0, 64, 1, 1, 0},  // R6 small drift
    '{ 0, 590, 250, 64, 1, 1, 0},  // R6 LNA frozen
    '{ 0, 440, 250, 64, 1, 1, 0},  // R6 drift exactly 150
    '{ 0, 439,   0, 64, 1, 0, 0},  // R7 drift 151
    '{40, 900, 250, 90, 0, 0, 0},  // R8 off, upper clamp
    '{ 0, 900, 180, 89, 0, 0, 0},  // R9 hysteresis hold
    '{ 0, 900, 149, 59, 1, 0, 0},  // R9 on
    '{ 0, 100, 170, 59, 1, 0, 0}   // R10 below band
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rx_start = 1'b0;
  logic          smp_vld = 1'b0;
  logic          smp_sat = 1'b0;
  logic [AW-1:0] smp_mag = '0;
  logic [PW-1:0] rf_pwr = '0;
  logic [GW-1:0] gain_code;
  logic          lna_en, agc_lock, lock_pulse;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  agc_ctrl u_agc_ctrl (
    .clk(clk), .rst(rst), .rx_start(rx_start),
    .smp_vld(smp_vld), .smp_sat(smp_sat), .smp_mag(smp_mag), .rf_pwr(rf_pwr),
    .gain_code(gain_code), .lna_en(lna_en), .agc_lock(agc_lock), .lock_pulse(lock_pulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input int g, input int l, input int k, input int p);
    chk({req, " gain"}, int'(gain_code), g);
    chk({req, " lna"}, int'(lna_en), l);
    chk({req, " lock"}, int'(agc_lock), k);
    chk({req, " pulse"}, int'(lock_pulse), p);
  endtask

  task automatic feed(input int n, input int nsat, input int mag);
    for (int i = 0; i < n; i++) begin
      smp_vld = 1'b1;
      smp_sat = (i < nsat);
      smp_mag = AW'(mag);
      @(negedge clk);
    end
    smp_vld = 1'b0;
    smp_sat = 1'b0;
  endtask

  task automatic run_window(input int nsat, input int mag, input int rf);
    rf_pwr = PW'(rf);
    feed(64, nsat, mag);
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000 && !done) begin
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_all("R1 reset", 90, 1, 0, 0);

    for (int v = 0; v < NV; v++) begin
      run_window(VEC[v][0], VEC[v][1], VEC[v][2]);
      chk_all($sformatf("R3/R5-R10 row%0d", v), VEC[v][3], VEC[v][4], VEC[v][5], VEC[v][6]);
      @(negedge clk);
      chk($sformatf("R5 pulse width row%0d", v), int'(lock_pulse), 0);
    end

    // R2: invalid cycles do not count
    rf_pwr = PW'(170);
    feed(63, 0, 900);
    repeat (5) @(negedge clk);
    chk("R2 short window gain", int'(gain_code), 59);
    feed(1, 0, 900);
    chk("R2 not yet due", int'(gain_code), 59);
    @(negedge clk);
    chk("R2 window complete", int'(gain_code), 58);

    // R1: rx_start
    rx_start = 1'b1;
    @(negedge clk);
    rx_start = 1'b0;
    chk_all("R1 rx_start", 90, 1, 0, 0);

    // R4: lower clamp through coarse steps
    for (int k = 1; k <= 13; k++) begin
      run_window(40, 900, 170);
      chk($sformatf("R4 clamp step%0d", k), int'(gain_code), (90 - 8 * k < 0) ? 0 : 90 - 8 * k);
    end

    run_window(0, 900, 250);
    chk_all("R8 off from zero gain", 30, 0, 0, 0);
    run_window(0, 900, 100);
    chk_all("R9 on with lower clamp", 0, 1, 0, 0);

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk_all("R1 mid-run reset", 90, 1, 0, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule